// File: doc/BRIEF.md
# Prescaled Reload Timer with Waveform Output

This block is a parameterised up-counter (32 bits by default) that advances either on every functional clock or once per power-of-two prescaled period. It runs in one-shot or auto-reload fashion. Software can reload it from a load register by pulsing a trigger strobe, or it can overwrite the count directly. A compare unit reports when an advance lands on a programmed value.

Overflow and match events can drive a waveform pin. The pin either inverts on each event or emits a pulse away from its idle level, and the pulse lasts one prescaled period. A freeze input stops counting while the chip is halted for debug, unless a free-run bit overrides it. A general-purpose bit is passed to its own output pin.

The surrounding register file drives the configuration inputs as levels and the write actions as one-clock strobes. It reads back `count` and `running`.

Top module: `ptick_timer`

## Requirements
- R1: After synchronous reset, `count` is 0, `running` is 0, and `ovf_evt`, `match_evt`, `pwm_out` and `gpo_out` are all 0.
- R2: With `psc_en`=1 the count advances once every 2^(`psc_val`+1) clocks while running. With `psc_en`=0 it advances on every clock.
- R3: When an advance passes all ones with `autoreload`=1, the count takes `load_val`. `ovf_evt` is high for exactly the one clock in which that value first shows, and `running` stays 1.
- R4: With `autoreload`=0, overflow sets the count to 0 and clears `running`. The counter then holds.
- R5: A `reload_strobe` pulse loads `load_val` into the count on the next clock and restarts the prescaler phase. This happens whatever `autoreload` and `running` are.
- R6: `match_evt` pulses for one clock when an advance brings the count to `cmp_val`, and only if `cmp_en`=1.
- R7: With `toggle_mode`=1 the pin inverts on each trigger event. `trig_mode` 1 selects overflow only, and `trig_mode` 2 selects overflow and match. The pin changes in the same clock as the event strobe.
- R8: With `toggle_mode`=0, each trigger event drives the pin to the opposite of `def_pol` until the next prescaled advance.
- R9: With `trig_mode` 0 or 3 the pin sits at `def_pol`, one clock after the setting is applied.
- R10: With `free_run`=0 and `suspend`=1 the count holds. With `free_run`=1 it keeps counting while `suspend`=1.
- R11: A `cnt_wr` pulse puts `cnt_din` into the count on the next clock, ahead of any reload or advance, and restarts the prescaler phase.
- R12: `gpo_out` follows `gpo_in` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Strobe: write the run bit |
| start_din | input | 1 | Value written to the run bit |
| autoreload | input | 1 | 1 = reload on overflow, 0 = one-shot |
| psc_en | input | 1 | Prescaler enable |
| psc_val | input | 3 | Prescale exponent; division is 2^(value+1) |
| cmp_en | input | 1 | Compare enable |
| cmp_val | input | 32 | Compare value |
| load_val | input | 32 | Reload value |
| trig_mode | input | 2 | 0 none, 1 overflow, 2 overflow and match, 3 none |
| toggle_mode | input | 1 | 1 = toggle, 0 = pulse |
| def_pol | input | 1 | Idle pin level; 1 gives negative pulses |
| reload_strobe | input | 1 | Strobe: load the count from `load_val` |
| cnt_wr | input | 1 | Strobe: write the count directly |
| cnt_din | input | 32 | Direct count value |
| free_run | input | 1 | 1 = ignore `suspend` |
| suspend | input | 1 | Debug halt request |
| gpo_in | input | 1 | General-purpose bit |
| count | output | 32 | Current count |
| running | output | 1 | Run bit, cleared by one-shot overflow |
| ovf_evt | output | 1 | Overflow strobe |
| match_evt | output | 1 | Compare-match strobe |
| pwm_out | output | 1 | Waveform pin |
| gpo_out | output | 1 | General-purpose pin |

## Verification
The assertions assume that `load_val` is never all ones. They also assume that `def_pol` changes only while the counter is stopped or the trigger is off. The pin checks compare against the polarity of one clock earlier, and a change mid-pulse would otherwise look like a spurious edge. The stimulus changes polarity only while `trig_mode` is 0, before each run starts. Every load value it programs stays at least one below all ones, so the overflow checks stay within what the assertions take for granted.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    TRG_NONE = 2'd0,
    TRG_OVF  = 2'd1,
    TRG_BOTH = 2'd2,
    TRG_RSVD = 2'd3
  } trg_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             psc_en,
  input  logic [PSC_W-1:0] psc_val,
  input  logic             clear,
  output logic             tick
);
  localparam int DIV_W = 1 << PSC_W;

  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] lim;
  logic             term;

  // terminal phase value is 2^(psc_val+1)-1
  always_comb begin
    for (int i = 0; i < DIV_W; i++) lim[i] = (i <= int'(psc_val));
  end

  assign term = (phase == lim);
  assign tick = enable && (!psc_en || term);

  always_ff @(posedge clk) begin
    if (rst || clear) phase <= '0;
    else if (enable && psc_en) phase <= term ? '0 : phase + 1'b1;
  end

  // R2: bypassed prescaler advances on every enabled clock
  p_bypass_tick_r2: assert property (@(posedge clk) disable iff (rst)
    (enable && !psc_en) |-> tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             autoreload,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_din,
  input  logic             reload_strobe,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             start_wr,
  input  logic             start_din,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             ovf_evt,
  output logic             match_evt,
  output logic             ovf_now,
  output logic             match_now
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             at_max;
  logic             adv;

  assign at_max    = (count == {CNT_W{1'b1}});
  assign adv       = tick && !cnt_wr && !reload_strobe;
  assign ovf_now   = adv && at_max;
  assign match_now = adv && cmp_en && (cnt_nxt == cmp_val);

  always_comb begin
    if (cnt_wr)             cnt_nxt = cnt_din;
    else if (reload_strobe) cnt_nxt = load_val;
    else if (tick) begin
      if (at_max) cnt_nxt = autoreload ? load_val : '0;
      else        cnt_nxt = count + 1'b1;
    end
    else cnt_nxt = count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      running   <= 1'b0;
      ovf_evt   <= 1'b0;
      match_evt <= 1'b0;
    end else begin
      count     <= cnt_nxt;
      ovf_evt   <= ovf_now;
      match_evt <= match_now;
      if (start_wr)                  running <= start_din;
      else if (ovf_now && !autoreload) running <= 1'b0;
    end
  end

  // R3: auto-reload overflow lands on the load value
  p_ovf_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (ovf_now && autoreload) |=> (count == $past(load_val)) && ovf_evt);
  // R4: one-shot overflow stops the timer
  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (rst)
    (ovf_now && !autoreload && !start_wr) |=> !running && (count == '0));
  // R6: a match strobe means the count equals the compare value
  p_match_value_r6: assert property (@(posedge clk) disable iff (rst)
    match_evt |-> $past(cmp_en) && (count == $past(cmp_val)));
  // R11: direct write wins over every other source
  p_direct_write_r11: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> count == $past(cnt_din));
endmodule

// File: rtl/tmr_outpin.sv
module tmr_outpin
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      ovf_now,
  input  logic      match_now,
  input  trg_mode_e trig_mode,
  input  logic      toggle_mode,
  input  logic      def_pol,
  output logic      pwm_out
);
  logic tgl_q, tgl_n;
  logic pls_q, pls_n;
  logic trig_on, trig_ev;

  assign trig_on = (trig_mode == TRG_OVF) || (trig_mode == TRG_BOTH);
  assign trig_ev = ((trig_mode == TRG_OVF)  && ovf_now) ||
                   ((trig_mode == TRG_BOTH) && (ovf_now || match_now));

  always_comb begin
    tgl_n = tgl_q;
    pls_n = pls_q;
    if (!trig_on) begin
      tgl_n = 1'b0;
      pls_n = 1'b0;
    end else if (trig_ev) begin
      tgl_n = ~tgl_q;
      pls_n = 1'b1;
    end else if (tick) begin
      pls_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_q   <= 1'b0;
      pls_q   <= 1'b0;
      pwm_out <= 1'b0;
    end else begin
      tgl_q   <= tgl_n;
      pls_q   <= pls_n;
      pwm_out <= def_pol ^ (toggle_mode ? tgl_n : pls_n);
    end
  end

  // R9: trigger off leaves the pin at the idle level
  p_idle_level_r9: assert property (@(posedge clk) disable iff (rst)
    !trig_on |=> pwm_out == $past(def_pol));
  // R7: in toggle mode the pin moves exactly on trigger events
  p_toggle_edge_r7: assert property (@(posedge clk) disable iff (rst)
    (trig_on && toggle_mode && !trig_ev && $past(toggle_mode) && $stable(def_pol))
      |=> $stable(pwm_out));
endmodule

// File: rtl/ptick_timer.sv
module ptick_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_wr,
  input  logic             start_din,
  input  logic             autoreload,
  input  logic             psc_en,
  input  logic [PSC_W-1:0] psc_val,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0] load_val,
  input  logic [1:0]       trig_mode,
  input  logic             toggle_mode,
  input  logic             def_pol,
  input  logic             reload_strobe,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_din,
  input  logic             free_run,
  input  logic             suspend,
  input  logic             gpo_in,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             ovf_evt,
  output logic             match_evt,
  output logic             pwm_out,
  output logic             gpo_out
);
  logic enable, tick, ovf_now, match_now;

  assign enable = running && (free_run || !suspend);

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .enable(enable), .psc_en(psc_en),
    .psc_val(psc_val), .clear(cnt_wr || reload_strobe), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .autoreload(autoreload),
    .load_val(load_val), .cnt_wr(cnt_wr), .cnt_din(cnt_din),
    .reload_strobe(reload_strobe), .cmp_en(cmp_en), .cmp_val(cmp_val),
    .start_wr(start_wr), .start_din(start_din), .count(count),
    .running(running), .ovf_evt(ovf_evt), .match_evt(match_evt),
    .ovf_now(ovf_now), .match_now(match_now)
  );

  tmr_outpin u_pin (
    .clk(clk), .rst(rst), .tick(tick), .ovf_now(ovf_now),
    .match_now(match_now), .trig_mode(trg_mode_e'(trig_mode)),
    .toggle_mode(toggle_mode), .def_pol(def_pol), .pwm_out(pwm_out)
  );

  always_ff @(posedge clk) begin
    if (rst) gpo_out <= 1'b0;
    else     gpo_out <= gpo_in;
  end

  // R10: a halted, non-free-running counter holds its value
  p_freeze_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (suspend && !free_run && !cnt_wr && !reload_strobe) |=> $stable(count));
  // R5: the trigger strobe reloads in any mode
  p_reload_any_r5: assert property (@(posedge clk) disable iff (rst)
    (reload_strobe && !cnt_wr) |=> count == $past(load_val));
endmodule

// File: tb/tb_ptick_timer.sv
`timescale 1ns/1ps
module tb_ptick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_wr = 0, start_din = 0, autoreload = 0, psc_en = 0;
  logic [2:0]  psc_val = 0;
  logic        cmp_en = 0;
  logic [31:0] cmp_val = 0, load_val = 0, cnt_din = 0;
  logic [1:0]  trig_mode = 0;
  logic        toggle_mode = 0, def_pol = 0, reload_strobe = 0, cnt_wr = 0;
  logic        free_run = 0, suspend = 0, gpo_in = 0;
  logic [31:0] count;
  logic        running, ovf_evt, match_evt, pwm_out, gpo_out;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] c0;

  always #2 clk = ~clk;

  ptick_timer dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(logic [31:0] lv);
    load_val = lv; reload_strobe = 1; start_wr = 1; start_din = 1;
    step(1);
    reload_strobe = 0; start_wr = 0;
  endtask

  task automatic halt();
    start_wr = 1; start_din = 0; trig_mode = 0;
    step(1);
    start_wr = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 0;
    step(1);
    chk("R1 count", count, 0);
    chk("R1 running", running, 0);
    chk("R1 events", {ovf_evt, match_evt, pwm_out, gpo_out}, 0);

    // R2: prescaler sweep over every exponent
    for (int v = 0; v < 8; v++) begin
      int d;
      d = 2 << v;
      halt(); psc_en = 1; psc_val = 3'(v);
      go(0);
      step(3 * d - 1);
      chk("R2 before 3rd tick", count, 2);
      step(1);
      chk("R2 at 3rd tick", count, 3);
    end
    halt(); psc_en = 0;
    go(0); step(7);
    chk("R2 bypass every clock", count, 7);

    // R3: auto-reload overflow
    halt(); autoreload = 1;
    go(32'hFFFF_FFFC); step(3);
    chk("R3 at max", count, 32'hFFFF_FFFF);
    chk("R3 no early ovf", ovf_evt, 0);
    step(1);
    chk("R3 reload value", count, 32'hFFFF_FFFC);
    chk("R3 ovf strobe", ovf_evt, 1);
    chk("R3 still running", running, 1);
    step(1);
    chk("R3 strobe one clock", ovf_evt, 0);

    // R4: one-shot
    halt(); autoreload = 0;
    go(32'hFFFF_FFFC); step(4);
    chk("R4 wraps to zero", count, 0);
    chk("R4 ovf strobe", ovf_evt, 1);
    chk("R4 run cleared", running, 0);
    step(5);
    chk("R4 holds", count, 0);

    // R5: reload while stopped
    load_val = 32'h1234; reload_strobe = 1; step(1); reload_strobe = 0;
    chk("R5 reload when stopped", count, 32'h1234);
    chk("R5 stays stopped", running, 0);
    // R5: reload restarts prescaler phase (divide by 4)
    psc_en = 1; psc_val = 1;
    go(0); step(6);
    chk("R5 mid phase", count, 1);
    load_val = 32'h40; reload_strobe = 1; step(1); reload_strobe = 0;
    step(3);
    chk("R5 phase restarted hold", count, 32'h40);
    step(1);
    chk("R5 phase restarted tick", count, 32'h41);

    // R6: compare match
    halt(); psc_en = 0; cmp_en = 1; cmp_val = 5;
    go(0); step(4);
    chk("R6 no match yet", match_evt, 0);
    step(1);
    chk("R6 match strobe", match_evt, 1);
    step(1);
    chk("R6 match one clock", match_evt, 0);
    halt(); cmp_en = 0;
    go(0); step(5);
    chk("R6 disabled no match", match_evt, 0);

    // R7: toggle on overflow and match
    halt(); autoreload = 1; cmp_en = 1; cmp_val = 32'hFFFF_FFFE;
    toggle_mode = 1; def_pol = 0; step(1);
    trig_mode = 2; go(32'hFFFF_FFFC); step(1);
    chk("R7 idle before event", pwm_out, 0);
    step(1);
    chk("R7 toggle on match", pwm_out, 1);
    step(2);
    chk("R7 toggle on overflow", pwm_out, 0);
    step(2);
    chk("R7 toggle again", pwm_out, 1);
    // R7: overflow-only mode ignores match
    halt(); step(1);
    trig_mode = 1; go(32'hFFFF_FFFC); step(2);
    chk("R7 match ignored in mode 1", pwm_out, 0);
    step(2);
    chk("R7 overflow toggles mode 1", pwm_out, 1);

    // R9: trigger off holds idle level
    halt(); def_pol = 1; step(1);
    chk("R9 idle high mode 0", pwm_out, 1);
    trig_mode = 3; go(32'hFFFF_FFFC); step(5);
    chk("R9 mode 3 idle", pwm_out, 1);

    // R8: negative pulse, one prescaled period wide (divide by 2)
    halt(); cmp_en = 0; toggle_mode = 0; psc_en = 1; psc_val = 0; step(1);
    trig_mode = 1; go(32'hFFFF_FFFE); step(3);
    chk("R8 idle before", pwm_out, 1);
    step(1);
    chk("R8 pulse start", pwm_out, 0);
    step(1);
    chk("R8 pulse held", pwm_out, 0);
    step(1);
    chk("R8 pulse end", pwm_out, 1);

    // R10: freeze
    halt(); def_pol = 0; psc_en = 0; autoreload = 1;
    go(0); step(3);
    suspend = 1; free_run = 0;
    c0 = count; step(5);
    chk("R10 frozen", count, c0);
    free_run = 1; step(3);
    chk("R10 free run", count, c0 + 3);
    suspend = 0; free_run = 0;

    // R11: direct write with phase restart (divide by 4)
    halt(); psc_en = 1; psc_val = 1;
    go(0); step(6);
    cnt_wr = 1; cnt_din = 32'h10; load_val = 32'h99; reload_strobe = 1;
    step(1); cnt_wr = 0; reload_strobe = 0;
    chk("R11 write wins", count, 32'h10);
    step(3);
    chk("R11 phase restart hold", count, 32'h10);
    step(1);
    chk("R11 phase restart tick", count, 32'h11);

    // R12: general-purpose bit
    gpo_in = 1; step(1);
    chk("R12 gpo high", gpo_out, 1);
    gpo_in = 0; step(1);
    chk("R12 gpo low", gpo_out, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule